// File: doc/BRIEF.md
# Multiplexed LED Grid Scanner with Dimming

This block scans a common-cathode LED panel one digit at a time. It pulls one grid line low for a fixed slot of sixteen sub-slot ticks and drives that digit's segment pattern on the segment lines. A clock-enable input supplies the ticks. The segment pattern comes from a display memory. Each digit owns two bytes of that memory. The block reads both bytes at once through a read port with two byte lanes, addressed by the digit number.

There are two panel arrangements. The first has six grids and twelve segments. The second has seven grids and eleven segments. One output pin carries segment twelve in the first arrangement and grid seven in the second. A 3-bit brightness code sets how many of the sixteen ticks in each slot the segments stay lit. The steps are not linear. A display switch blanks every output without stopping the scan. After the last slot of every frame, a one-cycle strobe tells a key scanner that the frame has ended.

Top module: `led_grid_scanner`

## Requirements
- R1: After reset the block is in the seven-grid mode with brightness code 000 and the display off. segOut is 0, gridN is all ones, segGrid is 1, ramDigit is 0 and endOfCycle is 0.
- R2: Each slot lasts 16 accepted ticks (tickEn high at a clock edge). Digits are scanned from 0 up to the last digit and then wrap to 0. While the display is on, only the current digit's grid is low.
- R3: Brightness code 000..111 lights the segments for the first 1, 2, 4, 10, 11, 12, 13 or 14 ticks of each slot. A control write shows on the outputs after the second clock edge that follows it.
- R4: While the display is off, segOut is 0, gridN is all ones and segGrid is inactive. The scan position and endOfCycle still advance exactly as they do when the display is on.
- R5: modeWr with modeSel 2'b10 selects six grids and 2'b11 selects seven grids. A value that differs from the current mode turns the display off and restarts the scan at digit 0, tick 0. A write in the same cycle as such a mode change is dropped. Writing the current mode changes nothing.
- R6: modeWr with modeSel 2'b00 or 2'b01 is ignored.
- R7: Segment mapping. segOut[7:0] = ramLo[7:0] and segOut[10:8] = ramHi[2:0]. Segment twelve is ramHi[3]. ramHi[7:4] is never shown.
- R8: In six-grid mode, segGrid is segment twelve and is active high. In seven-grid mode, segGrid is grid seven (digit 6) and is active low.
- R9: endOfCycle is high for exactly one clock. That clock follows the edge that accepts the 16th tick of the last digit (digit 5 in six-grid mode, digit 6 in seven-grid mode).
- R10: ramDigit always equals the current digit number. The segment outputs show the lanes read at that number after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Sub-slot tick enable |
| modeWr | input | 1 | Mode register write strobe |
| modeSel | input | 2 | Mode code (10: six grids, 11: seven grids) |
| ctlWr | input | 1 | Display control write strobe |
| ctlDim | input | 3 | Brightness code |
| ctlOn | input | 1 | Display on (1) or off (0) |
| ramDigit | output | 3 | Digit number presented to the display memory |
| ramLo | input | 8 | Even byte of the addressed digit |
| ramHi | input | 8 | Odd byte of the addressed digit |
| segOut | output | 11 | Segments 1..11, active high |
| gridN | output | 6 | Grids 1..6, active low |
| segGrid | output | 1 | Segment 12 or grid 7, depending on the mode |
| endOfCycle | output | 1 | One-cycle end-of-frame strobe |

## Verification
A write or a tick changes state at the edge that accepts it. The registered outputs then follow one edge later, so every result is due after the second edge. The one exception is endOfCycle, which is already high after the first edge. Each bench task therefore drives a strobe for one clock, takes endOfCycle at the next falling edge, and waits one more falling edge before it compares segments, grids and the shared pin. The bench tracks its own digit and tick position and derives every expected output from it. Mode changes put both the design and the bench back at digit 0, tick 0.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int SUB_TICKS  = 16;
  localparam int TICK_W     = $clog2(SUB_TICKS);
  localparam int NUM_DIGITS = 7;
  localparam int SLOT_W     = $clog2(NUM_DIGITS);
  localparam int GRID_PINS  = 6;
  localparam int SEG_PINS   = 11;
  localparam int BYTE_W     = 8;

  typedef struct packed {
    logic              segOn;
    logic              gridOn;
    logic [SLOT_W-1:0] slot;
    logic              wide;
  } scanStrb_t;

  function automatic logic [TICK_W:0] pulseWidth(input logic [2:0] dim);
    case (dim)
      3'd0:    pulseWidth = 5'd1;
      3'd1:    pulseWidth = 5'd2;
      3'd2:    pulseWidth = 5'd4;
      default: pulseWidth = 5'(7 + dim);
    endcase
  endfunction
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import led_scan_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            tickEn,
  input  logic            modeWr,
  input  logic [1:0]      modeSel,
  input  logic            ctlWr,
  input  logic [2:0]      ctlDim,
  input  logic            ctlOn,
  output scanStrb_t       strb,
  output logic            endOfCycle
);
  logic              wide;
  logic              dispOn;
  logic [2:0]        dim;
  logic [SLOT_W-1:0] slot;
  logic [TICK_W-1:0] tickCnt;
  logic [SLOT_W-1:0] lastSlot;
  logic              modeChange;
  logic              slotEnd;

  assign modeChange = modeWr && modeSel[1] && (modeSel[0] == wide);
  assign lastSlot   = wide ? SLOT_W'(NUM_DIGITS - 2) : SLOT_W'(NUM_DIGITS - 1);
  assign slotEnd    = tickEn && (tickCnt == TICK_W'(SUB_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wide       <= 1'b0;
      dispOn     <= 1'b0;
      dim        <= 3'd0;
      slot       <= '0;
      tickCnt    <= '0;
      endOfCycle <= 1'b0;
    end else if (modeChange) begin
      wide       <= ~modeSel[0];
      dispOn     <= 1'b0;
      slot       <= '0;
      tickCnt    <= '0;
      endOfCycle <= 1'b0;
    end else begin
      if (ctlWr) begin
        dim    <= ctlDim;
        dispOn <= ctlOn;
      end
      endOfCycle <= slotEnd && (slot == lastSlot);
      if (tickEn) tickCnt <= tickCnt + 1'b1;
      if (slotEnd) slot <= (slot == lastSlot) ? '0 : slot + 1'b1;
    end
  end

  always_comb begin
    strb.segOn  = dispOn && ({1'b0, tickCnt} < pulseWidth(dim));
    strb.gridOn = dispOn;
    strb.slot   = slot;
    strb.wide   = wide;
  end

  // R5
  mode_change_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |=> (!dispOn && slot == '0 && tickCnt == '0));
  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    slot <= lastSlot);
  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotEnd && !modeChange) |=> (tickCnt == '0));
  // R9
  eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    endOfCycle |=> !endOfCycle);
endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import led_scan_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  scanStrb_t           strb,
  input  logic [BYTE_W-1:0]   ramLo,
  input  logic [BYTE_W-1:0]   ramHi,
  output logic [SEG_PINS-1:0] segOut,
  output logic [GRID_PINS-1:0] gridN,
  output logic                segGrid
);
  logic [SEG_PINS:0] segBits;

  assign segBits = {ramHi[SEG_PINS-BYTE_W:0], ramLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) segOut <= '0;
    else       segOut <= strb.segOn ? segBits[SEG_PINS-1:0] : '0;
  end

  for (genvar g = 0; g < GRID_PINS; g++) begin : gGrid
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) gridN[g] <= 1'b1;
      else       gridN[g] <= !(strb.gridOn && strb.slot == SLOT_W'(g));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          segGrid <= 1'b1;
    else if (strb.wide) segGrid <= strb.segOn && segBits[SEG_PINS];
    else                segGrid <= !(strb.gridOn && strb.slot == SLOT_W'(GRID_PINS));
  end

  // R2
  grid_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~gridN));
  // R4
  off_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.gridOn |=> (segOut == '0 && &gridN));
  // R8
  shared_grid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wide && strb.slot != SLOT_W'(GRID_PINS)) |=> segGrid);
endmodule

// File: rtl/led_grid_scanner.sv
module led_grid_scanner
  import led_scan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 modeWr,
  input  logic [1:0]           modeSel,
  input  logic                 ctlWr,
  input  logic [2:0]           ctlDim,
  input  logic                 ctlOn,
  output logic [SLOT_W-1:0]    ramDigit,
  input  logic [BYTE_W-1:0]    ramLo,
  input  logic [BYTE_W-1:0]    ramHi,
  output logic [SEG_PINS-1:0]  segOut,
  output logic [GRID_PINS-1:0] gridN,
  output logic                 segGrid,
  output logic                 endOfCycle
);
  scanStrb_t strb;

  scan_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .modeWr(modeWr), .modeSel(modeSel),
    .ctlWr(ctlWr), .ctlDim(ctlDim), .ctlOn(ctlOn),
    .strb(strb), .endOfCycle(endOfCycle)
  );

  seg_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ramLo(ramLo), .ramHi(ramHi),
    .segOut(segOut), .gridN(gridN), .segGrid(segGrid)
  );

  assign ramDigit = strb.slot;
endmodule

// File: tb/sim_led_grid_scanner.sv
module sim_led_grid_scanner;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, modeWr = 1'b0, ctlWr = 1'b0, ctlOn = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [2:0] ctlDim = 3'd0;
  logic [2:0] ramDigit;
  logic [7:0] ramLo, ramHi;
  logic [10:0] segOut;
  logic [5:0] gridN;
  logic segGrid, endOfCycle;
  logic [7:0] memLo [8];
  logic [7:0] memHi [8];
  int total = 0, bad = 0;
  logic eocSeen;
  bit finished = 0;

  always #2 clk = ~clk;

  led_grid_scanner u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modeWr(modeWr), .modeSel(modeSel),
    .ctlWr(ctlWr), .ctlDim(ctlDim), .ctlOn(ctlOn), .ramDigit(ramDigit),
    .ramLo(ramLo), .ramHi(ramHi), .segOut(segOut), .gridN(gridN),
    .segGrid(segGrid), .endOfCycle(endOfCycle)
  );

  assign ramLo = memLo[ramDigit];
  assign ramHi = memHi[ramDigit];

  function automatic int pwOf(input int d);
    int tbl [8] = '{1, 2, 4, 10, 11, 12, 13, 14};
    return tbl[d];
  endfunction

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) tickEn = 1'b1;
    @(negedge clk) tickEn = 1'b0;
    eocSeen = endOfCycle;
    @(negedge clk);
  endtask

  task automatic ctlWrite(input int d, input bit on);
    @(negedge clk) begin ctlWr = 1'b1; ctlDim = 3'(d); ctlOn = on; end
    @(negedge clk) ctlWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic modeWrite(input logic [1:0] m);
    @(negedge clk) begin modeWr = 1'b1; modeSel = m; end
    @(negedge clk) modeWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 seg", segOut, 0);
    check("R1 grid", gridN, 6'h3F);
    check("R1 shared", segGrid, 1);
    check("R1 digit", ramDigit, 0);
    check("R1 eoc", endOfCycle, 0);
  endtask

  // Full frame from digit 0 tick 0; covers R2 R4 R7 R8 R9 R10
  task automatic runFrame(input int nGrids, input bit on, input int pw);
    for (int g = 0; g < nGrids; g++) begin
      for (int t = 0; t < 16; t++) begin
        int expSeg, expGrid, expSh;
        bit lit;
        lit = on && (t < pw);
        expSeg = lit ? {memHi[g][2:0], memLo[g]} : 0;
        expGrid = (on && g < 6) ? (~(1 << g) & 6'h3F) : 6'h3F;
        if (nGrids == 6) expSh = lit ? memHi[g][3] : 0;
        else             expSh = (on && g == 6) ? 0 : 1;
        check("R10 digit", ramDigit, g);
        check(on ? "R7 seg" : "R4 seg", segOut, expSeg);
        check(on ? "R2 grid" : "R4 grid", gridN, expGrid);
        check("R8 shared", segGrid, expSh);
        tick();
        check("R9 eoc", eocSeen, (g == nGrids - 1 && t == 15) ? 1 : 0);
      end
    end
    check("R2 wrap", ramDigit, 0);
  endtask

  task automatic testDimSweep();
    for (int d = 0; d < 8; d++) begin
      int cnt = 0;
      ctlWrite(d, 1'b1);
      for (int t = 0; t < 16; t++) begin
        if (segOut != 0) cnt++;
        tick();
      end
      check("R3 width", cnt, pwOf(d));
    end
  endtask

  task automatic testModes();
    // R5 same mode: display stays on
    modeWrite(2'b11);
    check("R5 same", ((gridN != 6'h3F) || !segGrid) ? 1 : 0, 1);
    // R5 new mode: off and restart
    modeWrite(2'b10);
    check("R5 off grid", gridN, 6'h3F);
    check("R5 off seg", segOut, 0);
    check("R5 restart", ramDigit, 0);
    // R6 invalid codes ignored: still six-grid (frame below is 6 long) and off
    modeWrite(2'b00);
    modeWrite(2'b01);
    check("R6 ignored", gridN, 6'h3F);
    ctlWrite(7, 1'b1);
    runFrame(6, 1'b1, 14);
    // R5 ctl write in same cycle as mode change is dropped
    @(negedge clk) begin modeWr = 1'b1; modeSel = 2'b11; ctlWr = 1'b1; ctlDim = 3'd2; ctlOn = 1'b1; end
    @(negedge clk) begin modeWr = 1'b0; ctlWr = 1'b0; end
    @(negedge clk);
    check("R5 drop ctl", gridN, 6'h3F);
    runFrame(7, 1'b0, 0);
  endtask

  initial begin
    for (int d = 0; d < 8; d++) begin
      memLo[d] = 8'h5A ^ 8'(d * 17);
      memHi[d] = 8'hA0 | 8'((d * 3) & 15);
    end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runFrame(7, 1'b0, 0);
    ctlWrite(3, 1'b1);
    runFrame(7, 1'b1, 10);
    testDimSweep();
    testModes();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule